// File: doc/BRIEF.md
# Load-Use and Memory-Port Stall Unit

This block sits beside the decode stage of a five-stage in-order pipeline and decides, every cycle, whether the front end must freeze. It looks at the source registers of the instruction in decode, the destination register of the instruction in execute together with that instruction's memory-read flag, and a flag that says the memory stage is accessing data memory. Two cases need a freeze. The first is a load whose result is wanted by the instruction right behind it: forwarding cannot bring that value in time. The second is a single memory port shared by fetch and data: a load or store in the memory stage takes the port for that cycle, so nothing can be fetched.

On a freeze the block drops the program-counter write enable and the fetch/decode register write enable, and raises a bubble signal. The pipeline uses the bubble signal to clear the control fields of the instruction entering execute, so the no-op has no effect. The data fields pass through unchanged. A load-use freeze lasts exactly one cycle. After it, the consumer issues and gets the loaded value by forwarding from the memory/writeback register. When both causes are present in the same cycle, they merge into one freeze. A build parameter selects whether the shared memory port exists. With separate memories, the data-access flag has no effect.

Top module: `hz_stall_unit`

## Requirements
- R1: When out of reset, `ex_mem_read` is 1, `ex_dst` is nonzero and equals a decode source `k` whose `id_src_used[k]` is 1 (source `k` occupies bits `[k*REG_W +: REG_W]` of `id_src_flat`), and no load-use freeze was raised in the previous cycle, then in that same cycle `pc_we`=0, `ifid_we`=0 and `ex_bubble`=1.
- R2: A destination of register 0 never causes a load-use freeze.
- R3: A decode source whose `id_src_used` bit is 0 never causes a load-use freeze, even when its register number matches.
- R4: When `ex_mem_read` is 0, no load-use freeze is raised.
- R5: No load-use freeze is raised in two consecutive cycles, so each hazard inserts exactly one bubble even if the decode and execute fields are held unchanged.
- R6: With `SHARED_MEM`=1, `mem_data_access`=1 freezes the front end in that same cycle, and it does so on every cycle in which it is set.
- R7: With `SHARED_MEM`=0, `mem_data_access` has no effect on any output.
- R8: When a load-use hazard and a memory-port conflict occur in the same cycle, exactly one freeze cycle results. That cycle still counts as the load-use freeze for R5.
- R9: In every cycle, `pc_we` equals `ifid_we`, and `ex_bubble` is their inverse.
- R10: While `rst_n` is 0, no freeze is raised (`pc_we`=1, `ifid_we`=1, `ex_bubble`=0), and the one-cycle memory of R5 is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_src_flat | input | NUM_SRC*REG_W | Decode-stage source register numbers, packed |
| id_src_used | input | NUM_SRC | One bit per source: the instruction actually reads it |
| ex_dst | input | REG_W | Execute-stage destination register number |
| ex_mem_read | input | 1 | Execute-stage instruction is a load |
| mem_data_access | input | 1 | Memory-stage instruction uses data memory this cycle |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode pipeline register write enable |
| ex_bubble | output | 1 | Clear control fields entering execute |

## Verification
The bench builds two copies with NUM_SRC=2 and REG_W=5: one with SHARED_MEM=1 and one with SHARED_MEM=0. Both receive identical inputs in every cycle. Placing them side by side shows, in the same cycle, the memory-port freeze in one copy and its absence in the other. Load-use matches on either source are exercised. Random destinations are drawn from a few small register numbers, so that matches, register 0 and merged freezes all occur frequently.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef struct packed {
        logic lu_guard;
    } hz_state_t;

    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic bubble;
    } hz_ctrl_t;

    localparam hz_ctrl_t HZ_RUN    = '{pc_we: 1'b1, ifid_we: 1'b1, bubble: 1'b0};
    localparam hz_ctrl_t HZ_FREEZE = '{pc_we: 1'b0, ifid_we: 1'b0, bubble: 1'b1};

endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic             used,
    input  logic [REG_W-1:0] dst,
    output logic             hit
);
    always_comb begin
        hit = used && (src == dst);
    end
endmodule

// File: rtl/hz_port_conflict.sv
module hz_port_conflict #(
    parameter bit SHARED_MEM = 1'b1
) (
    input  logic access,
    output logic steal
);
    generate
        if (SHARED_MEM) begin : g_shared
            assign steal = access;
        end else begin : g_split
            logic unused_access;
            assign unused_access = access;
            assign steal = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit
    import hz_pkg::*;
#(
    parameter int NUM_SRC    = 2,
    parameter int REG_W      = 5,
    parameter bit SHARED_MEM = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC*REG_W-1:0] id_src_flat,
    input  logic [NUM_SRC-1:0]       id_src_used,
    input  logic [REG_W-1:0]         ex_dst,
    input  logic                     ex_mem_read,
    input  logic                     mem_data_access,
    output logic                     pc_we,
    output logic                     ifid_we,
    output logic                     ex_bubble
);
    localparam int SRC_BITS = NUM_SRC * REG_W;

    hz_state_t          state_d, state_q;
    hz_ctrl_t           ctrl;
    logic [NUM_SRC-1:0] src_hit;
    logic               port_steal;
    logic               lu_raw;
    logic               lu_hit;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
            hz_src_match #(.REG_W(REG_W)) u_match (
                .src  (id_src_flat[gi*REG_W +: REG_W]),
                .used (id_src_used[gi]),
                .dst  (ex_dst),
                .hit  (src_hit[gi])
            );
        end
    endgenerate

    hz_port_conflict #(.SHARED_MEM(SHARED_MEM)) u_port (
        .access (mem_data_access),
        .steal  (port_steal)
    );

    always_comb begin
        state_d = state_q;
        lu_raw  = ex_mem_read && (ex_dst != '0) && (|src_hit);
        lu_hit  = rst_n && lu_raw && !state_q.lu_guard;
        ctrl    = HZ_RUN;
        if (rst_n && (lu_hit || port_steal)) begin
            ctrl = HZ_FREEZE;
        end
        state_d.lu_guard = lu_hit;
        if (!rst_n) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign pc_we     = ctrl.pc_we;
    assign ifid_we   = ctrl.ifid_we;
    assign ex_bubble = ctrl.bubble;

    logic [SRC_BITS-1:0] unused_width_ref;
    assign unused_width_ref = id_src_flat;

endmodule

// File: rtl/hz_stall_unit_chk.sv
module hz_stall_unit_chk #(
    parameter int NUM_SRC    = 2,
    parameter int REG_W      = 5,
    parameter bit SHARED_MEM = 1'b1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_SRC*REG_W-1:0] id_src_flat,
    input logic [NUM_SRC-1:0]       id_src_used,
    input logic [REG_W-1:0]         ex_dst,
    input logic                     ex_mem_read,
    input logic                     mem_data_access,
    input logic                     pc_we,
    input logic                     ifid_we,
    input logic                     ex_bubble,
    input logic                     lu_hit
);
    logic shared_access;
    assign shared_access = (SHARED_MEM != 1'b0) && mem_data_access;

    AST_OUTS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we == ifid_we) && (ex_bubble == !pc_we)); // R9

    AST_ONE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        lu_hit |=> !lu_hit); // R5

    AST_ZERO_DST: assert property (@(posedge clk) disable iff (!rst_n)
        ((ex_dst == '0) && !shared_access) |-> !ex_bubble); // R2

    AST_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_mem_read && !shared_access) |-> pc_we); // R4

    AST_NO_USED_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        ((id_src_used == '0) && !shared_access) |-> ifid_we); // R3

    AST_PORT_STEAL: assert property (@(posedge clk) disable iff (!rst_n)
        shared_access |-> ex_bubble); // R6

    AST_SPLIT_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        ((SHARED_MEM == 1'b0) && mem_data_access && !ex_mem_read) |-> pc_we); // R7

    always @(posedge clk) begin
        if (rst_n === 1'b0) begin
            AST_RESET_RUN: assert (pc_we && ifid_we && !ex_bubble); // R10
        end
    end

    logic [NUM_SRC*REG_W-1:0] unused_src;
    assign unused_src = id_src_flat;
endmodule

bind hz_stall_unit hz_stall_unit_chk #(
    .NUM_SRC    (NUM_SRC),
    .REG_W      (REG_W),
    .SHARED_MEM (SHARED_MEM)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .id_src_flat     (id_src_flat),
    .id_src_used     (id_src_used),
    .ex_dst          (ex_dst),
    .ex_mem_read     (ex_mem_read),
    .mem_data_access (mem_data_access),
    .pc_we           (pc_we),
    .ifid_we         (ifid_we),
    .ex_bubble       (ex_bubble),
    .lu_hit          (lu_hit)
);

// File: tb/hz_stall_unit_tb.sv
module hz_stall_unit_tb;
    localparam int NUM_SRC = 2;
    localparam int REG_W   = 5;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                     rst_n = 1'b0;
    logic [NUM_SRC*REG_W-1:0] src   = '0;
    logic [NUM_SRC-1:0]       used  = '0;
    logic [REG_W-1:0]         dst   = '0;
    logic                     mrd   = 1'b0;
    logic                     macc  = 1'b0;
    logic pc_a, if_a, bb_a, pc_b, if_b, bb_b;

    int errors = 0;
    int checks = 0;
    bit prev_lu = 1'b0;

    hz_stall_unit #(.NUM_SRC(NUM_SRC), .REG_W(REG_W), .SHARED_MEM(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .id_src_flat(src), .id_src_used(used),
        .ex_dst(dst), .ex_mem_read(mrd), .mem_data_access(macc),
        .pc_we(pc_a), .ifid_we(if_a), .ex_bubble(bb_a)
    );

    hz_stall_unit #(.NUM_SRC(NUM_SRC), .REG_W(REG_W), .SHARED_MEM(1'b0)) u_dut_split (
        .clk(clk), .rst_n(rst_n), .id_src_flat(src), .id_src_used(used),
        .ex_dst(dst), .ex_mem_read(mrd), .mem_data_access(macc),
        .pc_we(pc_b), .ifid_we(if_b), .ex_bubble(bb_b)
    );

    task automatic chk(input string tag, input string nm, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, nm, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic [REG_W-1:0] s0, input logic [REG_W-1:0] s1,
                        input logic [1:0] u, input logic [REG_W-1:0] d,
                        input logic mr, input logic ma, input string tag);
        bit lu, frz_shared, frz_split;
        @(negedge clk);
        rst_n = r; src = {s1, s0}; used = u; dst = d; mrd = mr; macc = ma;
        lu = r && mr && (d != 0) && ((u[0] && s0 == d) || (u[1] && s1 == d)) && !prev_lu;
        frz_shared = lu || (r && ma);
        frz_split  = lu;
        #5;
        chk(tag, "shared pc_we",    pc_a, !frz_shared);
        chk(tag, "shared ifid_we",  if_a, !frz_shared);
        chk(tag, "shared bubble",   bb_a, frz_shared);
        chk(tag, "split pc_we",     pc_b, !frz_split);
        chk(tag, "split ifid_we",   if_b, !frz_split);
        chk(tag, "split bubble",    bb_b, frz_split);
        @(posedge clk);
        prev_lu = lu;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R10: hazardous inputs while in reset
        step(0, 5'd3, 5'd0, 2'b01, 5'd3, 1, 1, "R10");
        step(0, 5'd3, 5'd0, 2'b01, 5'd3, 1, 1, "R10");
        step(1, 5'd0, 5'd0, 2'b00, 5'd0, 0, 0, "R10");
        // R1: match on source 0, then bubble in execute
        step(1, 5'd7, 5'd1, 2'b11, 5'd7, 1, 0, "R1");
        step(1, 5'd7, 5'd1, 2'b11, 5'd0, 0, 0, "R1");
        // R1: match on source 1 only
        step(1, 5'd2, 5'd9, 2'b10, 5'd9, 1, 0, "R1");
        step(1, 5'd0, 5'd0, 2'b00, 5'd0, 0, 0, "R1");
        // R5: fields held for three cycles
        step(1, 5'd4, 5'd4, 2'b11, 5'd4, 1, 0, "R5");
        step(1, 5'd4, 5'd4, 2'b11, 5'd4, 1, 0, "R5");
        step(1, 5'd4, 5'd4, 2'b11, 5'd4, 1, 0, "R5");
        step(1, 5'd0, 5'd0, 2'b00, 5'd0, 0, 0, "R5");
        // R2: destination register 0
        step(1, 5'd0, 5'd0, 2'b11, 5'd0, 1, 0, "R2");
        // R3: match on sources that are not read
        step(1, 5'd6, 5'd6, 2'b00, 5'd6, 1, 0, "R3");
        step(1, 5'd6, 5'd8, 2'b10, 5'd6, 1, 0, "R3");
        // R4: not a load
        step(1, 5'd6, 5'd6, 2'b11, 5'd6, 0, 0, "R4");
        // R6 and R7: memory-stage data access, two cycles in a row
        step(1, 5'd1, 5'd2, 2'b11, 5'd3, 0, 1, "R6");
        step(1, 5'd1, 5'd2, 2'b11, 5'd3, 1, 1, "R7");
        step(1, 5'd0, 5'd0, 2'b00, 5'd0, 0, 0, "R7");
        // R8: both causes together, then the held load-use fields
        step(1, 5'd5, 5'd0, 2'b01, 5'd5, 1, 1, "R8");
        step(1, 5'd5, 5'd0, 2'b01, 5'd5, 1, 0, "R8");
        step(1, 5'd0, 5'd0, 2'b00, 5'd0, 0, 0, "R8");
        // R9: random traffic over small register numbers
        for (int i = 0; i < 400; i++) begin
            step(1, REG_W'($urandom_range(0, 3)), REG_W'($urandom_range(0, 3)),
                 2'($urandom_range(0, 3)), REG_W'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0), "R9");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule